// File: doc/BRIEF.md
# Host Register Bus Interface with Split or Shared Address Pins

This block sits between an external processor's asynchronous parallel bus and a bank of 16-bit registers inside the chip. The processor selects the block with an active-low chip select. It reads with an active-low read strobe. It writes each byte lane with its own active-low strobe, and a lane is written when that strobe rises. Registers are addressed by word, so the address carries no byte-select bit.

A static strap chooses how the address arrives. With the strap low, a dedicated set of address pins carries the word address. With the strap high, the address is sent on data bits 6..1. The top address pin then serves as the address latch enable. The address seen while that enable is high is kept once it falls, and it is used for every following access until the enable rises again.

All bus strobes are brought into the core clock through two flip-flop stages. The register side is a plain synchronous port: address, one write enable per byte lane, write data and read data. A write enable lasts one core clock and is always accepted. The register file is expected to return read data combinationally for the presented address. The data bus is driven through an output enable and is released whenever no read is in progress.

Top module: `hbus_regport`

## Requirements
- R1: While reset is asserted, data_oe is 0, data_out is 0 and rf_we is 0.
- R2: With mux_mode at 0, rf_addr follows addr_in. addr_in[5] is word-address bit A6 and addr_in[0] is A1. The value of addr_in sampled at a clock edge appears on rf_addr after that edge.
- R3: With mux_mode at 1, addr_in[5] acts as the address latch enable and addr_in[4:0] are unused. While the enable is high, rf_addr takes data_in[6:1]. After the enable falls, rf_addr stays constant until the enable rises again.
- R4: A rising edge on byte_wr_n[0] while cs_n is low gives one pulse on rf_we[0]. rf_wdata[7:0] then holds data_in[7:0] as sampled at the edge that raises the pulse. If the strobe rise is first sampled at edge k, the pulse appears after edge k+2.
- R5: A rising edge on byte_wr_n[1] while cs_n is low gives one pulse on rf_we[1], with rf_wdata[15:8] from data_in[15:8]. Its latency is the same as in R4.
- R6: When both byte strobes rise at the same sampling edge, rf_we is 2'b11 for a single clock, so the full word is written in one operation.
- R7: Each rising strobe edge gives exactly one write pulse of one clock. Holding a strobe low or high for any time gives no further pulses.
- R8: While cs_n is high, strobes have no effect: rf_we stays 0, data_oe stays 0 and the register contents are unchanged.
- R9: When cs_n and rd_n are both low, data_oe rises two clocks after the condition is first sampled, and data_out then carries the word at rf_addr. Otherwise data_oe is 0 and data_out is 0.
- R10: mux_mode is changed only while reset is asserted. After a change made during reset, the new addressing mode governs the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | Addressing strap: 0 dedicated address pins, 1 address shared on data pins |
| addr_in | input | 6 | Word address A6..A1. In shared mode, bit 5 is the address latch enable |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_wr_n | input | 2 | Active-low write strobes. Bit 0 is the low byte, bit 1 the high byte |
| data_in | input | 16 | Data bus value from the pad |
| data_out | output | 16 | Data driven toward the pad during reads |
| data_oe | output | 1 | Pad output enable, high only during a read |
| rf_addr | output | 6 | Register word address |
| rf_we | output | 2 | Per-lane write enable, one clock per strobe edge |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Register read data for rf_addr |

## Verification
A corrupted edge-detect flop shows up within three clocks of a strobe change. The symptom is a missing pulse, a duplicate pulse or a pulse on the wrong lane on rf_we. A bad address latch stays hidden until the next access. It then appears as a wrong rf_addr beside the write pulse, or as the wrong word on data_out two clocks after a read starts. A read-enable fault shows on data_oe within one clock of the synchronised read condition, so every clock is compared against a model that tracks the raw pin history.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_SHARED = 1'b1
  } bus_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hbus_addr_cap.sv
module hbus_addr_cap
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q
);
  bus_mode_e mode;
  assign mode = bus_mode_e'(mux_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (mode == MODE_SPLIT) begin
      addr_q <= addr_pins;
    end else if (ale_s) begin
      addr_q <= data_in[ADDR_W:1];
    end
  end

  // R3: shared-mode address is frozen while the latch enable is low
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mode && !ale_s) |=> $stable(addr_q));
endmodule

// File: rtl/hbus_wr_ctl.sv
module hbus_wr_ctl #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_s_n,
  input  logic              cs_s_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata
);
  logic [LANES-1:0] wr_prev_n;
  logic [LANES-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_n <= '1;
    else        wr_prev_n <= wr_s_n;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rise[l] = wr_s_n[l] & ~wr_prev_n[l] & ~cs_s_n;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        we[l]          <= 1'b0;
        wdata[8*l +: 8] <= '0;
      end else begin
        we[l] <= rise[l];
        if (rise[l]) wdata[8*l +: 8] <= data_in[8*l +: 8];
      end
    end

    // R7: a write pulse never lasts more than one clock
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      we[l] |=> !we[l]);
  end

  // R8: no write pulse unless chip select was seen low
  a_r8_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (we != '0) |-> $past(!cs_s_n));
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mux_mode,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic [DATA_W/8-1:0]   byte_wr_n,
  input  logic [DATA_W-1:0]     data_in,
  output logic [DATA_W-1:0]     data_out,
  output logic                  data_oe,
  output logic [ADDR_W-1:0]     rf_addr,
  output logic [DATA_W/8-1:0]   rf_we,
  output logic [DATA_W-1:0]     rf_wdata,
  input  logic [DATA_W-1:0]     rf_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int SW    = LANES + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {(LANES + 2){1'b1}}};

  logic [SW-1:0]    sync_d, sync_q;
  logic             ale_s, cs_s_n, rd_s_n;
  logic [LANES-1:0] wr_s_n;
  logic             rd_act;

  assign sync_d = {addr_in[ADDR_W-1], byte_wr_n, rd_n, cs_n};
  assign {ale_s, wr_s_n, rd_s_n, cs_s_n} = sync_q;

  hbus_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q)
  );

  hbus_addr_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .ale_s(ale_s),
    .addr_pins(addr_in), .data_in(data_in), .addr_q(rf_addr)
  );

  hbus_wr_ctl #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_s_n(wr_s_n), .cs_s_n(cs_s_n),
    .data_in(data_in), .we(rf_we), .wdata(rf_wdata)
  );

  assign rd_act = ~cs_s_n & ~rd_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_act;
      data_out <= rd_act ? rf_rdata : '0;
    end
  end

  // R1: outputs quiet one clock into reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!data_oe && rf_we == '0));

  // R9: the pad is driven only after a synchronised read select
  a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(!cs_s_n && !rd_s_n));

  // R9: bus value is zero whenever the pad is released
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  // R10: strap does not move outside reset
  a_r10_strap_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mux_mode));
endmodule

// File: tb/tb_hbus_regport.sv
module tb_hbus_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0;
  logic [5:0] addr_in = '0;
  logic cs_n = 1'b1, rd_n = 1'b1;
  logic [1:0] byte_wr_n = 2'b11;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, rf_wdata, rf_rdata;
  logic data_oe;
  logic [5:0] rf_addr;
  logic [1:0] rf_we;

  always #5 clk = ~clk;

  hbus_regport dut (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .addr_in(addr_in),
    .cs_n(cs_n), .rd_n(rd_n), .byte_wr_n(byte_wr_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rf_addr(rf_addr),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // register file attached to the DUT, and the model's own copy
  logic [15:0] tb_mem [64];
  logic [15:0] ref_mem[64];
  assign rf_rdata = tb_mem[rf_addr];

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  // pin history: index 0 is the newest sample
  logic       h_cs[4], h_rd[4], h_ale[4];
  logic [1:0] h_wr[4];
  logic [15:0] h_dat[4];
  logic [5:0]  h_adr[4];
  logic [5:0]  ma;
  logic [1:0]  exp_we;
  logic        exp_oe;
  logic [15:0] exp_dout, exp_wdata;

  initial begin
    for (int i = 0; i < 64; i++) begin
      tb_mem[i]  = 16'(i * 16'h0101 + 16'h5000);
      ref_mem[i] = 16'(i * 16'h0101 + 16'h5000);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_cs[i] = 1'b1; h_rd[i] = 1'b1; h_ale[i] = 1'b0;
        h_wr[i] = 2'b11; h_dat[i] = '0; h_adr[i] = '0;
      end
      ma = '0; exp_we = '0; exp_oe = 1'b0; exp_dout = '0; exp_wdata = '0;
    end else begin
      for (int l = 0; l < 2; l++)
        if (rf_we[l]) tb_mem[rf_addr][8*l +: 8] = rf_wdata[8*l +: 8];
      for (int i = 3; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_rd[i] = h_rd[i-1]; h_ale[i] = h_ale[i-1];
        h_wr[i] = h_wr[i-1]; h_dat[i] = h_dat[i-1]; h_adr[i] = h_adr[i-1];
      end
      h_cs[0] = cs_n; h_rd[0] = rd_n; h_ale[0] = addr_in[5];
      h_wr[0] = byte_wr_n; h_dat[0] = data_in; h_adr[0] = addr_in;
      exp_oe   = !h_cs[2] && !h_rd[2];
      exp_dout = exp_oe ? ref_mem[ma] : 16'h0000;
      for (int l = 0; l < 2; l++)
        if (exp_we[l]) ref_mem[ma][8*l +: 8] = exp_wdata[8*l +: 8];
      if (!mux_mode)     ma = h_adr[0];
      else if (h_ale[2]) ma = h_dat[0][6:1];
      for (int l = 0; l < 2; l++)
        exp_we[l] = h_wr[2][l] && !h_wr[3][l] && !h_cs[2];
      exp_wdata = h_dat[0];
    end
  end

  function automatic void chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endfunction

  always @(negedge clk) begin
    if (cyc >= 2) begin
      chk(rf_we === exp_we, "rf_we", 32'(rf_we), 32'(exp_we));
      chk(data_oe === exp_oe, "data_oe", 32'(data_oe), 32'(exp_oe));
      chk(data_out === exp_dout, "data_out", 32'(data_out), 32'(exp_dout));
      if (rst_n && (exp_we != 2'b00 || exp_oe))
        chk(rf_addr === ma, "rf_addr", 32'(rf_addr), 32'(ma));
      if (rst_n && exp_we != 2'b00)
        chk((rf_wdata & {{8{exp_we[1]}}, {8{exp_we[0]}}}) ===
            (exp_wdata & {{8{exp_we[1]}}, {8{exp_we[0]}}}),
            "rf_wdata", 32'(rf_wdata), 32'(exp_wdata));
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(logic [5:0] a);
    if (!mux_mode) begin
      addr_in = a;
    end else begin
      data_in = {9'b0, a, 1'b0};
      addr_in = 6'b100000;
      wait_cyc(3);
      addr_in = 6'b000000;
      wait_cyc(4);
      data_in = 16'hA5A5;  // bus moves on, address must stay latched (R3)
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [15:0] d, logic [1:0] lanes,
                          bit sel, int hold);
    @(negedge clk);
    set_addr(a);
    data_in = d;
    cs_n = !sel;
    wait_cyc(2);
    byte_wr_n = ~lanes;
    wait_cyc(hold);
    byte_wr_n = 2'b11;
    wait_cyc(4);
    cs_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic do_read(logic [5:0] a, bit sel);
    @(negedge clk);
    set_addr(a);
    cs_n = !sel;
    rd_n = 1'b0;
    wait_cyc(6);
    rd_n = 1'b1;
    wait_cyc(3);
    cs_n = 1'b1;
    wait_cyc(3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    wait_cyc(6);
    rst_n = 1'b1;
    wait_cyc(3);

    tag = "R4"; do_write(6'd5, 16'h12AB, 2'b01, 1'b1, 4);
    tag = "R5"; do_write(6'd5, 16'hCD34, 2'b10, 1'b1, 4);
    tag = "R6"; do_write(6'd63, 16'hBEEF, 2'b11, 1'b1, 4);
    tag = "R6"; do_write(6'd0, 16'h0F0F, 2'b11, 1'b1, 3);
    tag = "R2"; do_read(6'd5, 1'b1);
    tag = "R2"; do_read(6'd63, 1'b1);
    tag = "R9"; do_read(6'd0, 1'b1);
    tag = "R7"; do_write(6'd10, 16'h7777, 2'b11, 1'b1, 15);
    tag = "R8"; do_write(6'd10, 16'hDEAD, 2'b11, 1'b0, 4);
    tag = "R8"; do_read(6'd10, 1'b0);
    tag = "R9"; do_read(6'd10, 1'b1);

    tag = "R10";
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    mux_mode = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    do_write(6'd21, 16'h2121, 2'b11, 1'b1, 4);
    tag = "R3"; do_write(6'd42, 16'h4200, 2'b10, 1'b1, 4);
    tag = "R3"; do_read(6'd21, 1'b1);
    tag = "R3"; do_read(6'd42, 1'b1);
    tag = "R3"; do_read(6'd5, 1'b1);
    tag = "R4"; do_write(6'd42, 16'h0099, 2'b01, 1'b1, 5);
    tag = "R9"; do_read(6'd42, 1'b1);

    wait_cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule